// File: doc/BRIEF.md
# Data Pointer Address Generator

This block forms the effective address for indirect loads, stores and program-memory accesses of an 8-bit microcontroller core. It takes the six register-file bytes that make up the three 16-bit pointers (X, Y, Z), together with an optional 8-bit extension byte per pointer. Each request selects a pointer, an addressing mode and a 6-bit displacement. The block returns the effective address right away. For program-memory accesses it also returns the byte-lane bit.

The new pointer value is returned one clock later for the register file to write back. Program-memory accesses always use Z, whatever the pointer select says. When the extension input is high, the extension byte sits above the 16-bit pointer and forms a 24-bit address. When it is low, the address space is 64 KB and pointer arithmetic wraps at 16 bits.

Top module: `ptr_agen`

## Requirements
- R1: Pointer select 0 picks X = {r27,r26}, 1 picks Y = {r29,r28}, and 2 or 3 pick Z = {r31,r30}. In each pair the higher-numbered register is the high byte.
- R2: Mode 0 (plain), and the unused codes 6 and 7, give the selected pointer as the address and request no write-back.
- R3: Mode 1 (pre-decrement) subtracts one from the pointer. That result is both the address and the write-back value.
- R4: Mode 2 (post-increment) gives the unmodified pointer as the address and writes back the pointer plus one.
- R5: Mode 3 (displacement) adds the unsigned 6-bit displacement (0 to 63) to Y or Z and requests no write-back. With X, the displacement is ignored and the address is X.
- R6: Mode 4 (program read) always uses Z. The address output carries the word address (the extended Z shifted right by one). byte_lane equals Z bit 0: 0 selects the low byte, 1 selects the high byte.
- R7: Mode 5 (program store) always uses Z and forces Z bit 0 to zero. align_err is raised during the strobe when Z bit 0 was set. The address is the word address, byte_lane is 0, and the write-back value is the aligned Z plus 2.
- R8: When ext_en is 1, the selected pointer's extension byte forms address bits 23:16. When ext_en is 0, those bits are zero.
- R9: Without extension, increments and decrements wrap modulo 2^16, and the returned extension byte equals its input. With extension, a carry or borrow propagates into the returned extension byte.
- R10: wb_valid is high exactly in the cycle after a strobe of a mode that updates the pointer (modes 1, 2 and 5). wb_sel, wb_ptr and wb_ext are valid in that same cycle. Reset clears wb_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Request valid this cycle |
| ptr_sel | input | 2 | Pointer select: 0 = X, 1 = Y, 2 or 3 = Z |
| mode | input | 3 | Addressing mode code (see R2 to R7) |
| disp | input | 6 | Unsigned displacement |
| ext_en | input | 1 | Use extension bytes (24-bit space) |
| r26 | input | 8 | X low byte |
| r27 | input | 8 | X high byte |
| r28 | input | 8 | Y low byte |
| r29 | input | 8 | Y high byte |
| r30 | input | 8 | Z low byte |
| r31 | input | 8 | Z high byte |
| x_ext | input | 8 | X extension byte |
| y_ext | input | 8 | Y extension byte |
| z_ext | input | 8 | Z extension byte |
| eff_addr | output | 24 | Effective data byte address, or program word address |
| byte_lane | output | 1 | Program read byte select |
| align_err | output | 1 | Odd Z seen on a program store |
| wb_valid | output | 1 | Write-back request |
| wb_sel | output | 2 | Pointer to write back |
| wb_ptr | output | 16 | New 16-bit pointer value |
| wb_ext | output | 8 | New extension byte |

## Verification
The bench targets wrap points. It decrements 0x0000 and increments 0xFFFF with and without extension: a design that carries at the wrong width gives a stale or spilled upper byte. It drives odd and even Z into both program modes. A design that shifts by the wrong amount, or misses the forced alignment, shows a wrong word address, a wrong lane bit or a write-back off by one. It tries the displacement with X and asks for program modes with a non-Z pointer selected, which exposes a design that honours the wrong pointer. It also checks that plain and displacement requests leave wb_valid low. A design that writes back on every strobe would corrupt the pointer.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
    parameter int PW = 16;
    parameter int EW = 8;
    parameter int DW = 6;
    localparam int AW = PW + EW;

    typedef enum logic [2:0] {
        M_PLAIN   = 3'd0,
        M_PREDEC  = 3'd1,
        M_POSTINC = 3'd2,
        M_DISP    = 3'd3,
        M_PROGRD  = 3'd4,
        M_PROGST  = 3'd5
    } amode_e;

    typedef enum logic [1:0] {
        SEL_X = 2'd0,
        SEL_Y = 2'd1,
        SEL_Z = 2'd2,
        SEL_Z2 = 2'd3
    } psel_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          lane;
        logic          misalign;
        logic          upd;
        logic [AW-1:0] next;
    } agen_res_t;

    // Add with carry confined to the pointer when the extension is off.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] b,
                                           input logic [AW-1:0] d,
                                           input logic en);
        logic [PW-1:0] lo;
        lo = b[PW-1:0] + d[PW-1:0];
        return en ? (b + d) : {b[AW-1:PW], lo};
    endfunction
endpackage

// File: rtl/ptr_agen_sel.sv
module ptr_agen_sel
    import ptr_agen_pkg::*;
(
    input  logic [1:0]    ptr_sel,
    input  logic [2:0]    mode,
    input  logic [7:0]    r26, r27, r28, r29, r30, r31,
    input  logic [EW-1:0] x_ext, y_ext, z_ext,
    output psel_e         eff_sel,
    output logic [PW-1:0] ptr,
    output logic [EW-1:0] ext
);
    logic prog;
    assign prog = (mode == M_PROGRD) || (mode == M_PROGST);

    always_comb begin
        eff_sel = prog ? SEL_Z : psel_e'(ptr_sel);
        unique case (eff_sel)
            SEL_X:   begin ptr = {r27, r26}; ext = x_ext; end
            SEL_Y:   begin ptr = {r29, r28}; ext = y_ext; end
            default: begin ptr = {r31, r30}; ext = z_ext; end
        endcase
    end
endmodule

// File: rtl/ptr_agen_calc.sv
module ptr_agen_calc
    import ptr_agen_pkg::*;
(
    input  logic [PW-1:0] ptr,
    input  logic [EW-1:0] ext,
    input  logic          ext_en,
    input  logic [2:0]    mode,
    input  psel_e         sel,
    input  logic [DW-1:0] disp,
    output agen_res_t     res
);
    logic [AW-1:0] full, aligned, dq;
    assign full    = ext_en ? {ext, ptr} : {{EW{1'b0}}, ptr};
    assign aligned = {full[AW-1:1], 1'b0};
    assign dq      = {{(AW-DW){1'b0}}, disp};

    always_comb begin
        res = '{addr: full, lane: 1'b0, misalign: 1'b0, upd: 1'b0, next: full};
        case (amode_e'(mode))
            M_PREDEC: begin
                res.next = step(full, {AW{1'b1}}, ext_en);
                res.addr = res.next;
                res.upd  = 1'b1;
            end
            M_POSTINC: begin
                res.next = step(full, AW'(1), ext_en);
                res.upd  = 1'b1;
            end
            M_DISP: begin
                if (sel != SEL_X) res.addr = step(full, dq, ext_en);
            end
            M_PROGRD: begin
                res.addr = full >> 1;
                res.lane = full[0];
            end
            M_PROGST: begin
                res.addr     = aligned >> 1;
                res.misalign = full[0];
                res.next     = step(aligned, AW'(2), ext_en);
                res.upd      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ptr_agen_wb.sv
module ptr_agen_wb
    import ptr_agen_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [1:0]    sel_d,
    input  logic [PW-1:0] ptr_d,
    input  logic [EW-1:0] ext_d,
    output logic          wb_valid,
    output logic [1:0]    wb_sel,
    output logic [PW-1:0] wb_ptr,
    output logic [EW-1:0] wb_ext
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_sel   <= '0;
            wb_ptr   <= '0;
            wb_ext   <= '0;
        end else begin
            wb_valid <= load;
            if (load) begin
                wb_sel <= sel_d;
                wb_ptr <= ptr_d;
                wb_ext <= ext_d;
            end
        end
    end

    // R10
    wb_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> !wb_valid);
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
    import ptr_agen_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [1:0]    ptr_sel,
    input  logic [2:0]    mode,
    input  logic [DW-1:0] disp,
    input  logic          ext_en,
    input  logic [7:0]    r26,
    input  logic [7:0]    r27,
    input  logic [7:0]    r28,
    input  logic [7:0]    r29,
    input  logic [7:0]    r30,
    input  logic [7:0]    r31,
    input  logic [EW-1:0] x_ext,
    input  logic [EW-1:0] y_ext,
    input  logic [EW-1:0] z_ext,
    output logic [AW-1:0] eff_addr,
    output logic          byte_lane,
    output logic          align_err,
    output logic          wb_valid,
    output logic [1:0]    wb_sel,
    output logic [PW-1:0] wb_ptr,
    output logic [EW-1:0] wb_ext
);
    psel_e         sel;
    logic [PW-1:0] ptr;
    logic [EW-1:0] ext;
    agen_res_t     res;
    logic [EW-1:0] ext_next;

    ptr_agen_sel sel_i (
        .ptr_sel(ptr_sel), .mode(mode),
        .r26(r26), .r27(r27), .r28(r28), .r29(r29), .r30(r30), .r31(r31),
        .x_ext(x_ext), .y_ext(y_ext), .z_ext(z_ext),
        .eff_sel(sel), .ptr(ptr), .ext(ext)
    );

    ptr_agen_calc calc_i (
        .ptr(ptr), .ext(ext), .ext_en(ext_en), .mode(mode),
        .sel(sel), .disp(disp), .res(res)
    );

    assign ext_next  = ext_en ? res.next[AW-1:PW] : ext;
    assign eff_addr  = res.addr;
    assign byte_lane = res.lane;
    assign align_err = strobe & res.misalign;

    ptr_agen_wb wb_i (
        .clk(clk), .rst(rst), .load(strobe & res.upd),
        .sel_d(sel), .ptr_d(res.next[PW-1:0]), .ext_d(ext_next),
        .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_ptr(wb_ptr), .wb_ext(wb_ext)
    );

    // R3
    predec_wb_chk: assert property (@(posedge clk) disable iff (rst)
        strobe && mode == M_PREDEC |=> wb_valid && wb_ptr == $past(eff_addr[PW-1:0]));
    // R4
    postinc_wb_chk: assert property (@(posedge clk) disable iff (rst)
        strobe && mode == M_POSTINC |=> wb_valid && wb_ptr == $past(eff_addr[PW-1:0]) + 16'd1);
    // R2
    plain_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        strobe && mode == M_PLAIN |=> !wb_valid);
    // R5
    disp_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        strobe && mode == M_DISP |=> !wb_valid);
    // R7
    store_lane_chk: assert property (@(posedge clk) disable iff (rst)
        strobe && mode == M_PROGST |-> !byte_lane);
    // R7
    store_wb_even_chk: assert property (@(posedge clk) disable iff (rst)
        strobe && mode == M_PROGST |=> wb_valid && wb_sel == 2'd2 && !wb_ptr[0]);
endmodule

// File: tb/ptr_agen_tb_top.sv
module ptr_agen_tb_top;
    logic clk = 1'b0, rst = 1'b1, strobe = 1'b0, ext_en = 1'b0;
    logic [1:0] ptr_sel = '0;
    logic [2:0] mode = '0;
    logic [5:0] disp = '0;
    logic [7:0] r26 = 0, r27 = 0, r28 = 0, r29 = 0, r30 = 0, r31 = 0;
    logic [7:0] x_ext = 0, y_ext = 0, z_ext = 0;
    logic [23:0] eff_addr;
    logic byte_lane, align_err, wb_valid;
    logic [1:0] wb_sel;
    logic [15:0] wb_ptr;
    logic [7:0] wb_ext;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ptr_agen dut_i (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic set_ptrs(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z,
                            input logic [7:0] xe, input logic [7:0] ye, input logic [7:0] ze);
        {r27, r26} = x; {r29, r28} = y; {r31, r30} = z;
        x_ext = xe; y_ext = ye; z_ext = ze;
    endtask

    // Issue one request; check combinational outputs, then the write-back a cycle later.
    task automatic req(input string r, input logic [1:0] s, input logic [2:0] m,
                       input logic [5:0] q, input logic en,
                       input logic [23:0] ea, input logic ln, input logic ae,
                       input logic wv, input logic [1:0] ws,
                       input logic [15:0] wp, input logic [7:0] we);
        @(negedge clk);
        ptr_sel = s; mode = m; disp = q; ext_en = en; strobe = 1'b1;
        #1;
        chk({r, " eff_addr"}, 32'(eff_addr), 32'(ea));
        chk({r, " byte_lane"}, 32'(byte_lane), 32'(ln));
        chk({r, " align_err"}, 32'(align_err), 32'(ae));
        @(posedge clk); #1;
        strobe = 1'b0;
        chk({r, " wb_valid"}, 32'(wb_valid), 32'(wv));
        if (wv) begin
            chk({r, " wb_sel"}, 32'(wb_sel), 32'(ws));
            chk({r, " wb_ptr"}, 32'(wb_ptr), 32'(wp));
            chk({r, " wb_ext"}, 32'(wb_ext), 32'(we));
        end
    endtask

    task automatic t_reset();
        #1 chk("R10 reset wb_valid", 32'(wb_valid), 0);
    endtask

    task automatic t_plain();
        set_ptrs(16'hA1B2, 16'h1234, 16'h5678, 8'h11, 8'h22, 8'h33);
        req("R1 R2 plain X", 2'd0, 3'd0, 6'd9, 1'b0, 24'h00A1B2, 0, 0, 0, 0, 0, 0);
        req("R1 R2 plain Y", 2'd1, 3'd0, 6'd0, 1'b0, 24'h001234, 0, 0, 0, 0, 0, 0);
        req("R1 R8 plain Z ext", 2'd3, 3'd0, 6'd0, 1'b1, 24'h335678, 0, 0, 0, 0, 0, 0);
        req("R2 unused mode 7", 2'd1, 3'd7, 6'd4, 1'b1, 24'h221234, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_predec();
        set_ptrs(16'h0100, 16'h0000, 16'h0000, 8'h05, 8'h05, 8'h00);
        req("R3 predec X", 2'd0, 3'd1, 6'd0, 1'b0, 24'h0000FF, 0, 0, 1, 2'd0, 16'h00FF, 8'h05);
        req("R3 R9 predec Y wrap", 2'd1, 3'd1, 6'd0, 1'b0, 24'h00FFFF, 0, 0, 1, 2'd1, 16'hFFFF, 8'h05);
        req("R3 R9 predec Y borrow ext", 2'd1, 3'd1, 6'd0, 1'b1, 24'h04FFFF, 0, 0, 1, 2'd1, 16'hFFFF, 8'h04);
    endtask

    task automatic t_postinc();
        set_ptrs(16'h0010, 16'h0000, 16'hFFFF, 8'h00, 8'h00, 8'h07);
        req("R4 postinc X", 2'd0, 3'd2, 6'd0, 1'b0, 24'h000010, 0, 0, 1, 2'd0, 16'h0011, 8'h00);
        req("R4 R9 postinc Z wrap", 2'd2, 3'd2, 6'd0, 1'b0, 24'h00FFFF, 0, 0, 1, 2'd2, 16'h0000, 8'h07);
        req("R4 R9 postinc Z carry ext", 2'd2, 3'd2, 6'd0, 1'b1, 24'h07FFFF, 0, 0, 1, 2'd2, 16'h0000, 8'h08);
    endtask

    task automatic t_disp();
        set_ptrs(16'h2000, 16'h1000, 16'hFFF0, 8'h00, 8'h00, 8'h02);
        req("R5 disp Y max q", 2'd1, 3'd3, 6'd63, 1'b0, 24'h00103F, 0, 0, 0, 0, 0, 0);
        req("R5 R8 disp Z ext carry", 2'd2, 3'd3, 6'h20, 1'b1, 24'h030010, 0, 0, 0, 0, 0, 0);
        req("R5 disp Z wrap no ext", 2'd2, 3'd3, 6'h20, 1'b0, 24'h000010, 0, 0, 0, 0, 0, 0);
        req("R5 disp X ignored", 2'd0, 3'd3, 6'd5, 1'b0, 24'h002000, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_progrd();
        set_ptrs(16'h4444, 16'h0000, 16'h1235, 8'h00, 8'h00, 8'h01);
        req("R6 progrd odd, X selected", 2'd0, 3'd4, 6'd0, 1'b0, 24'h00091A, 1, 0, 0, 0, 0, 0);
        set_ptrs(16'h4444, 16'h0000, 16'h1234, 8'h00, 8'h00, 8'h01);
        req("R6 progrd even", 2'd2, 3'd4, 6'd0, 1'b0, 24'h00091A, 0, 0, 0, 0, 0, 0);
        set_ptrs(16'h4444, 16'h0000, 16'h0003, 8'h00, 8'h00, 8'h01);
        req("R6 R8 progrd ext", 2'd2, 3'd4, 6'd0, 1'b1, 24'h008001, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_progst();
        set_ptrs(16'h0000, 16'h0000, 16'h2001, 8'h00, 8'h00, 8'h00);
        req("R7 progst odd, Y selected", 2'd1, 3'd5, 6'd0, 1'b0, 24'h001000, 0, 1, 1, 2'd2, 16'h2002, 8'h00);
        set_ptrs(16'h0000, 16'h0000, 16'h2000, 8'h00, 8'h00, 8'h00);
        req("R7 progst even", 2'd2, 3'd5, 6'd0, 1'b0, 24'h001000, 0, 0, 1, 2'd2, 16'h2002, 8'h00);
        set_ptrs(16'h0000, 16'h0000, 16'hFFFE, 8'h00, 8'h00, 8'h00);
        req("R7 R9 progst carry ext", 2'd2, 3'd5, 6'd0, 1'b1, 24'h007FFF, 0, 0, 1, 2'd2, 16'h0000, 8'h01);
    endtask

    task automatic t_idle();
        @(negedge clk); strobe = 1'b0; mode = 3'd2;
        @(posedge clk); #1;
        chk("R10 no strobe no wb", 32'(wb_valid), 0);
    endtask

    initial begin
        t_reset();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        t_plain();
        t_predec();
        t_postinc();
        t_disp();
        t_progrd();
        t_progst();
        t_idle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R10 watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule